// File: doc/BRIEF.md
# Flow-Steered Receive Packet DMA

This block accepts byte-wide packets from a streaming input and lands each one in a descriptor buffer. Every packet carries a flow number on its first beat. The flow number selects an entry in a small flow table. The entry names the free queue to draw a descriptor from, the completion queue to hand the filled descriptor to, and the buffer capacity in bytes. Descriptors are never walked from a fixed ring. The block asks a queue manager for one by popping the free queue of the flow, and it returns it by pushing to the destination queue. Recycling used descriptors back to a free queue is the consumer's job.

For each packet the block looks up the flow and pops a descriptor, holding the stream stalled until a non-empty pop answer arrives. It then writes the payload bytes after the descriptor header. It writes a length word into the descriptor header, and finally pushes the descriptor to the completion queue. Payload beyond the buffer capacity is dropped and flagged in the length word. A loopback select takes the packet stream from a transmit-side stream port instead of the receive port. With it, data sent out on the transmit side lands in memory at once.

Top module: `rxflow_dma`

## Requirements
- R1: After a cycle with reset (rst_n) low, pop_req, push_req, mem_we and dsc_we are all low, and s_ready and tx_ready are low.
- R2: When a first beat is presented while idle, the block raises pop_req with pop_qnum equal to the free-queue number of the beat's flow entry, and keeps both steady until a cycle with pop_ack high.
- R3: A pop answer with pop_empty high is not a descriptor: the block keeps pop_req high, keeps the stream stalled (ready low), and retries until an answer with pop_empty low arrives.
- R4: Payload byte k of a packet (k counted from 0) is written with mem_we at address mem_addr = descriptor + HDR_BYTES + k, one write per accepted beat, in arrival order.
- R5: Bytes at positions at or beyond the flow's buffer size are accepted but not written. The length word then holds the buffer size in bits LW-1:0 and has the error bit, bit LW, set to 1.
- R6: After the last beat, one dsc_we write of the length word goes to dsc_addr equal to the descriptor address. push_req rises in the very next cycle.
- R7: push_req carries push_qnum equal to the flow's destination-queue number and push_desc equal to the popped descriptor. Both are held steady until push_ack.
- R8: With lpbk_en high, packets come from the tx_* port, s_ready stays low, and any beats on the s_* port are ignored.
- R9: Descriptors are pushed in the order their packets arrived. A new pop never starts before the previous packet's push completes.
- R10: A flow-table write (cfg_we) in the same cycle as the first-beat lookup of that flow leaves that packet on the old entry. The next packet of the flow uses the new entry.
- R11: A packet no longer than the buffer gets a length word equal to its byte count with the error bit (bit LW) at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpbk_en | input | 1 | Take packets from the tx_* port instead of the s_* port |
| s_valid | input | 1 | Receive stream beat valid |
| s_ready | output | 1 | Receive stream beat accepted |
| s_data | input | DW | Receive stream payload byte |
| s_last | input | 1 | Last beat of packet |
| s_flow | input | FW | Flow number, sampled on the first beat |
| tx_valid | input | 1 | Looped transmit stream beat valid |
| tx_ready | output | 1 | Looped transmit stream beat accepted |
| tx_data | input | DW | Looped transmit payload byte |
| tx_last | input | 1 | Looped transmit last beat |
| tx_flow | input | FW | Looped transmit flow number |
| cfg_we | input | 1 | Flow table entry write |
| cfg_flow | input | FW | Entry index to write |
| cfg_free_q | input | QW | Free queue number for the entry |
| cfg_dest_q | input | QW | Completion queue number for the entry |
| cfg_buf_size | input | LW | Buffer capacity in bytes for the entry |
| pop_req | output | 1 | Descriptor pop request |
| pop_qnum | output | QW | Queue to pop |
| pop_ack | input | 1 | Pop answer valid this cycle |
| pop_empty | input | 1 | Pop answer: queue was empty |
| pop_desc | input | AW | Pop answer: descriptor address |
| mem_we | output | 1 | Payload byte write |
| mem_addr | output | AW | Payload byte address |
| mem_wdata | output | DW | Payload byte |
| dsc_we | output | 1 | Length word write |
| dsc_addr | output | AW | Descriptor address of the length word |
| dsc_wdata | output | LW+1 | Error bit (bit LW) and stored length |
| push_req | output | 1 | Completion push request |
| push_qnum | output | QW | Completion queue number |
| push_desc | output | AW | Descriptor being pushed |
| push_ack | input | 1 | Push accepted this cycle |

## Verification
Two functions can fall on the same clock edge: the flow lookup for a new packet and a write into the flow table. A directed case first waits for the block to go idle. It then drives a packet's first beat and a table write for that same flow in one cycle. The bench judges the outcome from the queue numbers, the length word and the truncation flag it observes: the packet must carry the old entry's queue numbers and buffer size, and the packet after it must carry the new ones. Around this, random packets arrive back to back over random flows and lengths, with pop and push answers delayed at random and forced empty pops, so every state boundary sees both fresh and stalled stimulus.

// File: rtl/rxf_pkg.sv
// Package rxf_pkg
// Shared types for the flow-steered receive DMA.
// Assumes: nothing beyond the standard language.
package rxf_pkg;

    // Per-packet progress of the receive engine
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a first beat
        ST_POP,    // asking the free queue for a descriptor
        ST_DATA,   // moving payload beats into the buffer
        ST_LEN,    // writing the length word into the descriptor
        ST_PUSH    // handing the descriptor to the completion queue
    } rxf_state_e;

endpackage

// File: rtl/rxf_flow_table.sv
// Module rxf_flow_table
// Holds one entry per flow: free queue, completion queue, buffer size.
// One write port, one combinational read port. A write and a read of the
// same entry in one cycle return the old entry (write lands at the edge).
// Assumes: wr_idx and rd_idx are below FLOWS.
module rxf_flow_table #(
    parameter int FLOWS = 8,
    parameter int QW    = 12,
    parameter int LW    = 12,
    localparam int FW   = $clog2(FLOWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [FW-1:0] wr_idx,
    input  logic [QW-1:0] wr_free,
    input  logic [QW-1:0] wr_dest,
    input  logic [LW-1:0] wr_size,
    input  logic [FW-1:0] rd_idx,
    output logic [QW-1:0] rd_free,
    output logic [QW-1:0] rd_dest,
    output logic [LW-1:0] rd_size
);

    logic [QW-1:0] free_q [FLOWS];
    logic [QW-1:0] dest_q [FLOWS];
    logic [LW-1:0] size_q [FLOWS];

    for (genvar g = 0; g < FLOWS; g++) begin : g_entry
        // Store one flow entry on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                free_q[g] <= '0;
                dest_q[g] <= '0;
                size_q[g] <= '0;
            end else if (wr_en && (wr_idx == FW'(g))) begin
                free_q[g] <= wr_free;
                dest_q[g] <= wr_dest;
                size_q[g] <= wr_size;
            end
        end
    end

    // Read the selected entry
    always_comb begin
        rd_free = free_q[rd_idx];
        rd_dest = dest_q[rd_idx];
        rd_size = size_q[rd_idx];
    end

endmodule

// File: rtl/rxf_stream_sel.sv
// Module rxf_stream_sel
// Chooses the packet source: the receive port normally, the looped
// transmit port when loop is high. The unselected port sees ready low.
// Assumes: loop only changes while the engine is not taking beats.
module rxf_stream_sel #(
    parameter int DW = 8,
    parameter int FW = 3
) (
    input  logic          loop,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    input  logic [FW-1:0] rx_flow,
    output logic          rx_ready,
    input  logic          lb_valid,
    input  logic [DW-1:0] lb_data,
    input  logic          lb_last,
    input  logic [FW-1:0] lb_flow,
    output logic          lb_ready,
    output logic          o_valid,
    output logic [DW-1:0] o_data,
    output logic          o_last,
    output logic [FW-1:0] o_flow,
    input  logic          o_ready
);

    // Steer the chosen source forward and return ready to it alone
    always_comb begin
        o_valid  = loop ? lb_valid : rx_valid;
        o_data   = loop ? lb_data  : rx_data;
        o_last   = loop ? lb_last  : rx_last;
        o_flow   = loop ? lb_flow  : rx_flow;
        rx_ready = o_ready && !loop;
        lb_ready = o_ready &&  loop;
    end

endmodule

// File: rtl/rxf_engine.sv
// Module rxf_engine
// Per-packet sequencer: latch flow entry, pop a descriptor, write payload
// bytes after the header, write the length word, push the descriptor.
// One packet in flight, so completions leave in arrival order.
// Assumes: pop and push answers are single-cycle pulses that are only
// raised while the matching request is high; buffer size >= 1.
module rxf_engine #(
    parameter int QW        = 12,
    parameter int AW        = 16,
    parameter int LW        = 12,
    parameter int DW        = 8,
    parameter int HDR_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic [QW-1:0] tbl_free,
    input  logic [QW-1:0] tbl_dest,
    input  logic [LW-1:0] tbl_size,
    output logic          pop_req,
    output logic [QW-1:0] pop_qnum,
    input  logic          pop_ack,
    input  logic          pop_empty,
    input  logic [AW-1:0] pop_desc,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          dsc_we,
    output logic [AW-1:0] dsc_addr,
    output logic [LW:0]   dsc_wdata,
    output logic          push_req,
    output logic [QW-1:0] push_qnum,
    output logic [AW-1:0] push_desc,
    input  logic          push_ack
);
    import rxf_pkg::*;

    localparam logic [AW-1:0] HDR_OFS = AW'(HDR_BYTES);

    rxf_state_e    state;
    logic [QW-1:0] cur_free;
    logic [QW-1:0] cur_dest;
    logic [LW-1:0] cur_size;
    logic [AW-1:0] desc;
    logic [LW-1:0] stored;
    logic          trunc;
    logic          fits;

    assign fits = (stored < cur_size);

    // Advance the packet sequence and keep its per-packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_free <= '0;
            cur_dest <= '0;
            cur_size <= '0;
            desc     <= '0;
            stored   <= '0;
            trunc    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        cur_free <= tbl_free;
                        cur_dest <= tbl_dest;
                        cur_size <= tbl_size;
                        state    <= ST_POP;
                    end
                end
                ST_POP: begin
                    if (pop_ack && !pop_empty) begin
                        desc   <= pop_desc;
                        stored <= '0;
                        trunc  <= 1'b0;
                        state  <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (in_valid) begin
                        if (fits) stored <= stored + 1'b1;
                        else      trunc  <= 1'b1;
                        if (in_last) state <= ST_LEN;
                    end
                end
                ST_LEN: state <= ST_PUSH;
                ST_PUSH: begin
                    if (push_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the queue, memory and stream handshakes from the state
    always_comb begin
        in_ready  = (state == ST_DATA);
        pop_req   = (state == ST_POP);
        pop_qnum  = cur_free;
        mem_we    = (state == ST_DATA) && in_valid && fits;
        mem_addr  = desc + HDR_OFS + AW'(stored);
        mem_wdata = in_data;
        dsc_we    = (state == ST_LEN);
        dsc_addr  = desc;
        dsc_wdata = {trunc, stored};
        push_req  = (state == ST_PUSH);
        push_qnum = cur_dest;
        push_desc = desc;
    end

endmodule

// File: rtl/rxflow_dma.sv
// Module rxflow_dma
// Receive DMA steered by flow: each packet's flow picks the free queue,
// completion queue and buffer size. Optional loopback from the transmit
// stream port. Descriptor recycling is left to the consumer.
// Assumes: a queue manager answers pops and pushes with one-cycle pulses.
module rxflow_dma #(
    parameter int FLOWS     = 8,
    parameter int QW        = 12,
    parameter int AW        = 16,
    parameter int LW        = 12,
    parameter int DW        = 8,
    parameter int HDR_BYTES = 16,
    localparam int FW       = $clog2(FLOWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lpbk_en,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [DW-1:0] s_data,
    input  logic          s_last,
    input  logic [FW-1:0] s_flow,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_last,
    input  logic [FW-1:0] tx_flow,
    input  logic          cfg_we,
    input  logic [FW-1:0] cfg_flow,
    input  logic [QW-1:0] cfg_free_q,
    input  logic [QW-1:0] cfg_dest_q,
    input  logic [LW-1:0] cfg_buf_size,
    output logic          pop_req,
    output logic [QW-1:0] pop_qnum,
    input  logic          pop_ack,
    input  logic          pop_empty,
    input  logic [AW-1:0] pop_desc,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          dsc_we,
    output logic [AW-1:0] dsc_addr,
    output logic [LW:0]   dsc_wdata,
    output logic          push_req,
    output logic [QW-1:0] push_qnum,
    output logic [AW-1:0] push_desc,
    input  logic          push_ack
);

    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          in_last;
    logic [FW-1:0] in_flow;
    logic          in_ready;
    logic [QW-1:0] tbl_free;
    logic [QW-1:0] tbl_dest;
    logic [LW-1:0] tbl_size;

    rxf_stream_sel #(.DW(DW), .FW(FW)) u_sel (
        .loop     (lpbk_en),
        .rx_valid (s_valid),
        .rx_data  (s_data),
        .rx_last  (s_last),
        .rx_flow  (s_flow),
        .rx_ready (s_ready),
        .lb_valid (tx_valid),
        .lb_data  (tx_data),
        .lb_last  (tx_last),
        .lb_flow  (tx_flow),
        .lb_ready (tx_ready),
        .o_valid  (in_valid),
        .o_data   (in_data),
        .o_last   (in_last),
        .o_flow   (in_flow),
        .o_ready  (in_ready)
    );

    rxf_flow_table #(.FLOWS(FLOWS), .QW(QW), .LW(LW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_flow),
        .wr_free (cfg_free_q),
        .wr_dest (cfg_dest_q),
        .wr_size (cfg_buf_size),
        .rd_idx  (in_flow),
        .rd_free (tbl_free),
        .rd_dest (tbl_dest),
        .rd_size (tbl_size)
    );

    rxf_engine #(
        .QW(QW), .AW(AW), .LW(LW), .DW(DW), .HDR_BYTES(HDR_BYTES)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .tbl_free  (tbl_free),
        .tbl_dest  (tbl_dest),
        .tbl_size  (tbl_size),
        .pop_req   (pop_req),
        .pop_qnum  (pop_qnum),
        .pop_ack   (pop_ack),
        .pop_empty (pop_empty),
        .pop_desc  (pop_desc),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dsc_we    (dsc_we),
        .dsc_addr  (dsc_addr),
        .dsc_wdata (dsc_wdata),
        .push_req  (push_req),
        .push_qnum (push_qnum),
        .push_desc (push_desc),
        .push_ack  (push_ack)
    );

endmodule

// File: rtl/rxf_dma_chk.sv
// Module rxf_dma_chk
// Protocol properties of rxflow_dma, attached by bind below.
// Assumes: reset is synchronous and active low.
module rxf_dma_chk #(
    parameter int QW = 12,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lpbk_en,
    input logic          s_ready,
    input logic          tx_ready,
    input logic          pop_req,
    input logic [QW-1:0] pop_qnum,
    input logic          pop_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          dsc_we,
    input logic          push_req,
    input logic [QW-1:0] push_qnum,
    input logic [AW-1:0] push_desc,
    input logic          push_ack
);

    // R1: reset leaves every request and write strobe low
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !pop_req && !push_req && !mem_we && !dsc_we);

    // R2: an unanswered pop stays up with the same queue number
    a_r2_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !pop_ack |=> pop_req && $stable(pop_qnum));

    // R3: no beat is taken and no byte written while a pop is pending
    a_r3_stall_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> !s_ready && !tx_ready && !mem_we);

    // R4: consecutive payload writes go to consecutive addresses
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + AW'(1));

    // R6: the length word is followed at once by the push request
    a_r6_len_then_push: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_we |=> push_req && !dsc_we);

    // R7: an unanswered push keeps its queue and descriptor
    a_r7_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && !push_ack |=> push_req && $stable(push_qnum) && $stable(push_desc));

    // R8: the receive port is closed while loopback is selected
    a_r8_rx_closed_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en |-> !s_ready);

    // R9: a push never overlaps a pop or payload write
    a_r9_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> !pop_req && !mem_we);

endmodule

bind rxflow_dma rxf_dma_chk #(.QW(QW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lpbk_en   (lpbk_en),
    .s_ready   (s_ready),
    .tx_ready  (tx_ready),
    .pop_req   (pop_req),
    .pop_qnum  (pop_qnum),
    .pop_ack   (pop_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .dsc_we    (dsc_we),
    .push_req  (push_req),
    .push_qnum (push_qnum),
    .push_desc (push_desc),
    .push_ack  (push_ack)
);

// File: tb/rxflow_dma_bench.sv
// Bench for rxflow_dma: random and directed packets, a queue manager model
// with random delays, and a scoreboard of expected writes and pushes.
module rxflow_dma_bench;

    localparam int FLOWS = 8;
    localparam int QW    = 12;
    localparam int AW    = 16;
    localparam int LW    = 12;
    localparam int DW    = 8;
    localparam int HDR   = 16;
    localparam int FW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lpbk_en = 1'b0;
    logic          s_valid = 1'b0, s_ready, s_last = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic [FW-1:0] s_flow = '0;
    logic          tx_valid = 1'b0, tx_ready, tx_last = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [FW-1:0] tx_flow = '0;
    logic          cfg_we = 1'b0;
    logic [FW-1:0] cfg_flow = '0;
    logic [QW-1:0] cfg_free_q = '0, cfg_dest_q = '0;
    logic [LW-1:0] cfg_buf_size = '0;
    logic          pop_req, pop_ack = 1'b0, pop_empty = 1'b0;
    logic [QW-1:0] pop_qnum;
    logic [AW-1:0] pop_desc = '0;
    logic          mem_we, dsc_we, push_req, push_ack = 1'b0;
    logic [AW-1:0] mem_addr, dsc_addr, push_desc;
    logic [DW-1:0] mem_wdata;
    logic [LW:0]   dsc_wdata;
    logic [QW-1:0] push_qnum;

    always #2 clk = ~clk;

    rxflow_dma #(.FLOWS(FLOWS), .QW(QW), .AW(AW), .LW(LW), .DW(DW), .HDR_BYTES(HDR))
    u_rxflow_dma (
        .clk(clk), .rst_n(rst_n), .lpbk_en(lpbk_en),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .s_flow(s_flow),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_flow(tx_flow),
        .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_free_q(cfg_free_q), .cfg_dest_q(cfg_dest_q),
        .cfg_buf_size(cfg_buf_size),
        .pop_req(pop_req), .pop_qnum(pop_qnum), .pop_ack(pop_ack), .pop_empty(pop_empty), .pop_desc(pop_desc),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dsc_we(dsc_we), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata),
        .push_req(push_req), .push_qnum(push_qnum), .push_desc(push_desc), .push_ack(push_ack)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit running = 1'b0;

    int sh_fq [FLOWS];
    int sh_dq [FLOWS];
    int sh_sz [FLOWS];
    int p_fq [512];
    int p_dq [512];
    int p_sz [512];
    int p_len [512];
    int exp_q [$];
    int npid = 0;
    int next_done = 0;

    int force_empty = 0;
    int empties_seen = 0;
    int next_desc = 32'h1000;

    int cur_desc = 0;
    int widx = 0;
    bit dsc_seen = 1'b0;
    bit prev_dsc = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pbyte(input int pid, input int idx);
        return 8'(pid * 37 + idx * 11 + 5);
    endfunction

    function automatic int stored_len(input int pid);
        return (p_len[pid] < p_sz[pid]) ? p_len[pid] : p_sz[pid];
    endfunction

    function automatic int len_word(input int pid);
        return ((p_len[pid] > p_sz[pid]) ? (1 << LW) : 0) | stored_len(pid);
    endfunction

    // Queue manager model: answers pops and pushes after random delay
    always @(posedge clk) begin
        #1;
        pop_ack  = 1'b0;
        push_ack = 1'b0;
        if (rst_n && pop_req && ($urandom_range(0, 3) != 0)) begin
            pop_ack = 1'b1;
            if (force_empty > 0) begin
                force_empty--;
                empties_seen++;
                pop_empty = 1'b1;
                pop_desc  = 16'hDEAD;
            end else begin
                pop_empty = 1'b0;
                pop_desc  = AW'(next_desc);
                next_desc += 32'h200;
            end
        end
        if (rst_n && push_req && ($urandom_range(0, 2) != 0)) push_ack = 1'b1;
    end

    // Scoreboard: compares writes and pushes with the expected packets
    always @(negedge clk) begin
        if (rst_n && running) begin
            int pid;
            if (lpbk_en) chk(s_ready == 1'b0, "R8 rx port closed", s_ready, 0);
            if (prev_dsc) chk(push_req == 1'b1, "R6 push after length", push_req, 1);
            prev_dsc = dsc_we;
            pid = (exp_q.size() > 0) ? exp_q[0] : 0;
            if (pop_req && pop_ack) begin
                if (pop_empty) begin
                    chk(!s_ready && !tx_ready, "R3 stalled on empty", {s_ready, tx_ready}, 0);
                end else begin
                    chk(int'(pop_qnum) == p_fq[pid], "R2 free queue", pop_qnum, p_fq[pid]);
                    cur_desc = int'(pop_desc);
                    widx = 0;
                    dsc_seen = 1'b0;
                end
            end
            if (mem_we) begin
                chk(widx < p_sz[pid], "R5 no write past buffer", widx, p_sz[pid]);
                chk(int'(mem_addr) == ((cur_desc + HDR + widx) & 16'hFFFF), "R4 byte address",
                    mem_addr, cur_desc + HDR + widx);
                chk(mem_wdata == pbyte(pid, widx), "R4 byte value", mem_wdata, pbyte(pid, widx));
                widx++;
            end
            if (dsc_we) begin
                chk(int'(dsc_addr) == cur_desc, "R6 length word address", dsc_addr, cur_desc);
                chk(int'(dsc_wdata) == len_word(pid),
                    (p_len[pid] > p_sz[pid]) ? "R5 truncated length word" : "R11 length word",
                    dsc_wdata, len_word(pid));
                chk(widx == stored_len(pid), "R5 bytes written", widx, stored_len(pid));
                dsc_seen = 1'b1;
            end
            if (push_req && push_ack) begin
                chk(exp_q.size() > 0, "R9 push with no packet", 0, 1);
                if (exp_q.size() > 0) begin
                    pid = exp_q.pop_front();
                    chk(pid == next_done, "R9 completion order", pid, next_done);
                    next_done = pid + 1;
                    chk(int'(push_qnum) == p_dq[pid], "R7 completion queue", push_qnum, p_dq[pid]);
                    chk(int'(push_desc) == cur_desc, "R7 pushed descriptor", push_desc, cur_desc);
                    chk(dsc_seen, "R6 length before push", dsc_seen, 1);
                end
            end
        end
    end

    task automatic set_flow(input int f, input int fq, input int dq, input int sz);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_flow = FW'(f);
        cfg_free_q = QW'(fq); cfg_dest_q = QW'(dq); cfg_buf_size = LW'(sz);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        sh_fq[f] = fq; sh_dq[f] = dq; sh_sz[f] = sz;
    endtask

    // Drive one packet; col writes the same flow's entry with the first beat
    task automatic send_pkt(input int f, input int len, input bit lb,
                            input bit col, input int nfq, input int ndq, input int nsz);
        int pid = npid++;
        p_fq[pid] = sh_fq[f]; p_dq[pid] = sh_dq[f]; p_sz[pid] = sh_sz[f]; p_len[pid] = len;
        exp_q.push_back(pid);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            cfg_we = 1'b0;
            lpbk_en = lb;
            if (lb) begin
                tx_valid = 1'b1; tx_data = pbyte(pid, i); tx_last = (i == len - 1); tx_flow = FW'(f);
                s_valid = 1'b1; s_data = 8'hEE; s_last = 1'b1; s_flow = FW'(f + 1);
            end else begin
                s_valid = 1'b1; s_data = pbyte(pid, i); s_last = (i == len - 1); s_flow = FW'(f);
                tx_valid = 1'b0;
            end
            if (i == 0 && col) begin
                cfg_we = 1'b1; cfg_flow = FW'(f);
                cfg_free_q = QW'(nfq); cfg_dest_q = QW'(ndq); cfg_buf_size = LW'(nsz);
                sh_fq[f] = nfq; sh_dq[f] = ndq; sh_sz[f] = nsz;
            end
            while (!(lb ? tx_ready : s_ready)) begin
                @(posedge clk); #1;
                cfg_we = 1'b0;
            end
        end
        @(posedge clk); #1;
        cfg_we = 1'b0;
        tx_valid = 1'b0;
        if (!lb) s_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!pop_req && !push_req && !mem_we && !dsc_we, "R1 strobes in reset",
            {pop_req, push_req, mem_we, dsc_we}, 0);
        chk(!s_ready && !tx_ready, "R1 ready in reset", {s_ready, tx_ready}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        running = 1'b1;
        for (int f = 0; f < FLOWS; f++) set_flow(f, 10 + f, 100 + f, 8 + 4 * f);

        // Directed: fits, exact fit, one byte over
        send_pkt(0, 5, 1'b0, 1'b0, 0, 0, 0);
        send_pkt(1, 12, 1'b0, 1'b0, 0, 0, 0);
        send_pkt(1, 13, 1'b0, 1'b0, 0, 0, 0);
        wait_idle();

        // Directed R3: three empty pop answers before a descriptor
        force_empty = 3;
        empties_seen = 0;
        send_pkt(2, 4, 1'b0, 1'b0, 0, 0, 0);
        wait_idle();
        chk(empties_seen == 3, "R3 empty answers retried", empties_seen, 3);

        // Directed R8: loopback with junk on the receive port
        send_pkt(3, 6, 1'b1, 1'b0, 0, 0, 0);
        wait_idle();
        s_valid = 1'b0;
        @(posedge clk); #1;
        lpbk_en = 1'b0;

        // Directed R10: table write in the lookup cycle, then the next packet
        send_pkt(4, 9, 1'b0, 1'b1, 20, 120, 5);
        wait_idle();
        send_pkt(4, 9, 1'b0, 1'b0, 0, 0, 0);
        wait_idle();
        chk(next_done == npid, "R10 both packets completed", next_done, npid);

        // Random back-to-back packets (R9 ordering across sources and flows)
        for (int n = 0; n < 60; n++) begin
            int f = $urandom_range(0, FLOWS - 1);
            int len = $urandom_range(1, 40);
            bit lb = ($urandom_range(0, 3) == 0);
            if (n % 17 == 5) force_empty = $urandom_range(1, 3);
            send_pkt(f, len, lb, 1'b0, 0, 0, 0);
            if (lb) begin
                wait_idle();
                s_valid = 1'b0;
                @(posedge clk); #1;
                lpbk_en = 1'b0;
            end
        end
        wait_idle();
        chk(next_done == npid, "R9 all packets completed", next_done, npid);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d completions", next_done, npid);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule